// File: doc/BRIEF.md
# Shared Last-Level Cache Sensitivity Sampler and Way Partitioner

This block sets the policy for a last-level cache that CPU and GPU cores share. It works out whether the GPU workload gains anything from the cache. To do so, it runs a few GPU cores that always bypass the cache next to a few GPU cores that always fill at the most-recently-used position, and it compares the progress of the two groups. Every other GPU core follows the policy that wins. The block also divides the cache ways between the CPU and the GPU. It bases the split on per-stack-position hit counts, and it scales those counts by the access volume of each side. Without that scaling, the heavy GPU request stream would take most of the ways.

All evidence comes in as one-cycle event strobes, which the block turns into saturating counters. An epoch lasts a programmable number of cycles. At the end of each epoch the block makes both decisions, and it then halves every counter so that older history counts for less over time. Between epoch boundaries the outputs do not change. The cache controller uses the per-core bypass vector when it handles GPU fills, and the way mask when it chooses a victim.

Top module: `llc_share_policy`

## Requirements
- R1: While reset is held, the way mask has its lowest NUM_WAYS/2 bits set. The GPU is taken to be cache-sensitive, so follower cores insert and do not bypass.
- R2: GPU cores 0 to NUM_BYP_SAMPLES-1 always drive bypass 1. The next NUM_MRU_SAMPLES cores always drive bypass 0. Each remaining core drives the inverse of the sensitivity flag.
- R3: An epoch ends on every cycle whose running count plus one is at least epoch_len, so values 0 and 1 both end an epoch every cycle. The mask and the sensitivity flag change only on the clock edge at the end of an epoch.
- R4: At the end of an epoch, if the MRU-group count is at most the bypass-group count, the GPU becomes cache-insensitive and followers bypass.
- R5: At the end of an epoch, if the MRU-group count exceeds the bypass-group count plus margin, the GPU becomes cache-sensitive. If the MRU count lies strictly above the bypass count but not above bypass plus margin, the previous flag is kept.
- R6: The CPU way count starts at 1, and so does the GPU way count. For NUM_WAYS-2 steps, CPU hits at stack position c (its current way count) times the GPU access count is compared with GPU hits at position g times the CPU access count. The CPU gets the next way if its product is greater or equal; otherwise the GPU gets it.
- R7: Each side keeps at least one way: the mask is never all zeros and never all ones.
- R8: When the sensitivity flag decided in the same epoch is 1, the CPU way count is raised by CPU_BOOST, capped at NUM_WAYS-1. When the flag is 0, the greedy count is used as it is.
- R9: Each event strobe adds one to its counter, which saturates at its maximum. At the end of an epoch every counter loads (value plus this cycle's increment) shifted right by one.
- R10: Bit i of the way mask is 1 when way i belongs to the CPU. The CPU ways are always the lowest-numbered ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| epoch_len | input | EPOCH_W | Epoch length in cycles |
| margin | input | CNT_W | Hysteresis margin for switching to cache-sensitive |
| byp_perf_evt | input | 1 | Progress event from the bypass sample group |
| mru_perf_evt | input | 1 | Progress event from the MRU-insert sample group |
| cpu_acc_evt | input | 1 | One CPU access to the shared cache |
| gpu_acc_evt | input | 1 | One GPU access to the shared cache |
| cpu_hit_pos | input | NUM_WAYS | CPU hit at the stack position given by each bit |
| gpu_hit_pos | input | NUM_WAYS | GPU hit at the stack position given by each bit |
| way_mask | output | NUM_WAYS | 1 = way owned by the CPU |
| gpu_core_bypass | output | NUM_GPU_CORES | Per-GPU-core fill policy, 1 = bypass |
| gpu_sensitive | output | 1 | Current GPU cache-sensitivity flag |

## Verification
A strobe counts in the clock edge that samples it, so it first affects a decision at the next epoch-ending edge. The new mask and sensitivity flag show up right after that edge, and the per-core bypass vector follows in the same cycle with no extra delay. The bench keeps a cycle-level model that moves on every rising edge, and it compares every output at the following falling edge. The directed cases count events from reset to an epoch ending 20 cycles later, so each expected mask and flag is checked in the first falling edge after that boundary, and again between boundaries to confirm the outputs hold.

// File: rtl/llc_share_pkg.sv
package llc_share_pkg;

   // Outcome of comparing the two GPU sample groups at an epoch boundary
   typedef enum logic [1:0] {
      DUEL_KEEP      = 2'd0,
      DUEL_TO_BYPASS = 2'd1,
      DUEL_TO_MRU    = 2'd2
   } duel_verdict_e;

   // Index assignment inside the scalar performance counter bank
   localparam int PERF_BYP  = 0;
   localparam int PERF_MRU  = 1;
   localparam int PERF_CACC = 2;
   localparam int PERF_GACC = 3;
   localparam int PERF_NUM  = 4;

endpackage

// File: rtl/llc_epoch_timer.sv
module llc_epoch_timer #(
   parameter int EPOCH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EPOCH_W-1:0] epoch_len,
   output logic               epoch_end
);

   logic [EPOCH_W-1:0] elapsed;

   // Lengths 0 and 1 both close an epoch on every cycle
   assign epoch_end = (({1'b0, elapsed} + 1'b1) >= {1'b0, epoch_len});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed <= '0;
      end else if (epoch_end) begin
         elapsed <= '0;
      end else begin
         elapsed <= elapsed + 1'b1;
      end
   end

endmodule

// File: rtl/llc_ctr_bank.sv
module llc_ctr_bank #(
   parameter int NUM = 4,
   parameter int W   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM-1:0]        inc,
   input  logic                  halve,
   output logic [NUM-1:0][W-1:0] cnt
);

   localparam logic [W-1:0] SAT_MAX = {W{1'b1}};

   for (genvar i = 0; i < NUM; i++) begin : g_ctr
      logic [W-1:0] val;
      logic [W-1:0] bumped;

      assign bumped = (inc[i] && (val != SAT_MAX)) ? val + 1'b1 : val;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val <= '0;
         end else if (halve) begin
            val <= bumped >> 1;
         end else begin
            val <= bumped;
         end
      end

      assign cnt[i] = val;
   end

endmodule

// File: rtl/llc_duel_decide.sv
module llc_duel_decide
   import llc_share_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evaluate,
   input  logic [CNT_W-1:0] byp_cnt,
   input  logic [CNT_W-1:0] mru_cnt,
   input  logic [CNT_W-1:0] margin,
   output logic             nxt_sensitive,
   output logic             sensitive
);

   duel_verdict_e    verdict;
   logic [CNT_W:0]   mru_ext;
   logic [CNT_W:0]   byp_ext;
   logic [CNT_W:0]   byp_plus_margin;

   assign mru_ext         = {1'b0, mru_cnt};
   assign byp_ext         = {1'b0, byp_cnt};
   assign byp_plus_margin = byp_ext + {1'b0, margin};

   always_comb begin
      if (mru_ext <= byp_ext) begin
         verdict = DUEL_TO_BYPASS;
      end else if (mru_ext > byp_plus_margin) begin
         verdict = DUEL_TO_MRU;
      end else begin
         verdict = DUEL_KEEP;
      end
   end

   always_comb begin
      unique case (verdict)
         DUEL_TO_BYPASS: nxt_sensitive = 1'b0;
         DUEL_TO_MRU:    nxt_sensitive = 1'b1;
         default:        nxt_sensitive = sensitive;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sensitive <= 1'b1;
      end else if (evaluate) begin
         sensitive <= nxt_sensitive;
      end
   end

endmodule

// File: rtl/llc_way_partition.sv
module llc_way_partition #(
   parameter int NUM_WAYS  = 8,
   parameter int CNT_W     = 16,
   parameter int CPU_BOOST = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       evaluate,
   input  logic                       boost_en,
   input  logic [NUM_WAYS-1:0][CNT_W-1:0] cpu_hits,
   input  logic [NUM_WAYS-1:0][CNT_W-1:0] gpu_hits,
   input  logic [CNT_W-1:0]           cpu_acc,
   input  logic [CNT_W-1:0]           gpu_acc,
   output logic [NUM_WAYS-1:0]        way_mask
);

   localparam int IDX_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
   localparam int PROD_W = 2 * CNT_W;
   localparam int STEPS  = NUM_WAYS - 2;

   int unsigned          greedy_cpu;
   int unsigned          cpu_final;
   logic [NUM_WAYS-1:0]  mask_nxt;

   // Greedy hand-out of the shared ways, utilities cross-scaled by the other side's access count
   always_comb begin
      int unsigned  c;
      int unsigned  g;
      logic [IDX_W-1:0] ci;
      logic [IDX_W-1:0] gi;
      logic [PROD_W-1:0] cpu_score;
      logic [PROD_W-1:0] gpu_score;
      c = 1;
      g = 1;
      for (int s = 0; s < STEPS; s++) begin
         ci        = c[IDX_W-1:0];
         gi        = g[IDX_W-1:0];
         cpu_score = {{CNT_W{1'b0}}, cpu_hits[ci]} * {{CNT_W{1'b0}}, gpu_acc};
         gpu_score = {{CNT_W{1'b0}}, gpu_hits[gi]} * {{CNT_W{1'b0}}, cpu_acc};
         if (cpu_score >= gpu_score) begin
            c = c + 1;
         end else begin
            g = g + 1;
         end
      end
      greedy_cpu = c;
   end

   if (CPU_BOOST > 0) begin : g_boost
      always_comb begin
         if (!boost_en) begin
            cpu_final = greedy_cpu;
         end else if (greedy_cpu + CPU_BOOST > NUM_WAYS - 1) begin
            cpu_final = NUM_WAYS - 1;
         end else begin
            cpu_final = greedy_cpu + CPU_BOOST;
         end
      end
   end else begin : g_plain
      logic unused_boost;
      assign unused_boost = boost_en;
      assign cpu_final    = greedy_cpu;
   end

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_mask
      localparam logic RESET_BIT = (w < NUM_WAYS / 2);

      assign mask_nxt[w] = (w < cpu_final);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            way_mask[w] <= RESET_BIT;
         end else if (evaluate) begin
            way_mask[w] <= mask_nxt[w];
         end
      end
   end

endmodule

// File: rtl/llc_share_policy.sv
module llc_share_policy
   import llc_share_pkg::*;
#(
   parameter int NUM_WAYS        = 8,
   parameter int NUM_GPU_CORES   = 8,
   parameter int NUM_BYP_SAMPLES = 1,
   parameter int NUM_MRU_SAMPLES = 1,
   parameter int CNT_W           = 16,
   parameter int EPOCH_W         = 16,
   parameter int CPU_BOOST       = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [EPOCH_W-1:0]       epoch_len,
   input  logic [CNT_W-1:0]         margin,
   input  logic                     byp_perf_evt,
   input  logic                     mru_perf_evt,
   input  logic                     cpu_acc_evt,
   input  logic                     gpu_acc_evt,
   input  logic [NUM_WAYS-1:0]      cpu_hit_pos,
   input  logic [NUM_WAYS-1:0]      gpu_hit_pos,
   output logic [NUM_WAYS-1:0]      way_mask,
   output logic [NUM_GPU_CORES-1:0] gpu_core_bypass,
   output logic                     gpu_sensitive
);

   localparam int SAMPLE_CORES = NUM_BYP_SAMPLES + NUM_MRU_SAMPLES;

   if (NUM_WAYS < 2) begin : g_bad_ways
      $error("NUM_WAYS must be at least 2");
   end
   if (NUM_BYP_SAMPLES < 1 || NUM_MRU_SAMPLES < 1) begin : g_bad_samples
      $error("each sample group needs at least one core");
   end
   if (SAMPLE_CORES > NUM_GPU_CORES) begin : g_bad_cores
      $error("sample groups exceed the GPU core count");
   end
   if (CPU_BOOST < 0 || CPU_BOOST >= NUM_WAYS) begin : g_bad_boost
      $error("CPU_BOOST out of range");
   end
   if (CNT_W < 2 || EPOCH_W < 1) begin : g_bad_widths
      $error("counter widths too small");
   end

   logic                             epoch_end;
   logic [PERF_NUM-1:0][CNT_W-1:0]   perf_cnt;
   logic [NUM_WAYS-1:0][CNT_W-1:0]   cpu_hits;
   logic [NUM_WAYS-1:0][CNT_W-1:0]   gpu_hits;
   logic [CNT_W-1:0]                 byp_cnt;
   logic [CNT_W-1:0]                 mru_cnt;
   logic                             nxt_sensitive;
   logic [PERF_NUM-1:0]              perf_inc;

   always_comb begin
      perf_inc            = '0;
      perf_inc[PERF_BYP]  = byp_perf_evt;
      perf_inc[PERF_MRU]  = mru_perf_evt;
      perf_inc[PERF_CACC] = cpu_acc_evt;
      perf_inc[PERF_GACC] = gpu_acc_evt;
   end

   llc_epoch_timer #(.EPOCH_W(EPOCH_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .epoch_len (epoch_len),
      .epoch_end (epoch_end)
   );

   llc_ctr_bank #(.NUM(PERF_NUM), .W(CNT_W)) u_perf_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (perf_inc),
      .halve (epoch_end),
      .cnt   (perf_cnt)
   );

   llc_ctr_bank #(.NUM(NUM_WAYS), .W(CNT_W)) u_cpu_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cpu_hit_pos),
      .halve (epoch_end),
      .cnt   (cpu_hits)
   );

   llc_ctr_bank #(.NUM(NUM_WAYS), .W(CNT_W)) u_gpu_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (gpu_hit_pos),
      .halve (epoch_end),
      .cnt   (gpu_hits)
   );

   assign byp_cnt = perf_cnt[PERF_BYP];
   assign mru_cnt = perf_cnt[PERF_MRU];

   llc_duel_decide #(.CNT_W(CNT_W)) u_decide (
      .clk           (clk),
      .rst_n         (rst_n),
      .evaluate      (epoch_end),
      .byp_cnt       (byp_cnt),
      .mru_cnt       (mru_cnt),
      .margin        (margin),
      .nxt_sensitive (nxt_sensitive),
      .sensitive     (gpu_sensitive)
   );

   llc_way_partition #(
      .NUM_WAYS  (NUM_WAYS),
      .CNT_W     (CNT_W),
      .CPU_BOOST (CPU_BOOST)
   ) u_partition (
      .clk      (clk),
      .rst_n    (rst_n),
      .evaluate (epoch_end),
      .boost_en (nxt_sensitive),
      .cpu_hits (cpu_hits),
      .gpu_hits (gpu_hits),
      .cpu_acc  (perf_cnt[PERF_CACC]),
      .gpu_acc  (perf_cnt[PERF_GACC]),
      .way_mask (way_mask)
   );

   // Fixed sample groups lead, followers take the decided policy
   for (genvar k = 0; k < NUM_GPU_CORES; k++) begin : g_core
      if (k < NUM_BYP_SAMPLES) begin : g_byp_sample
         assign gpu_core_bypass[k] = 1'b1;
      end else if (k < SAMPLE_CORES) begin : g_mru_sample
         assign gpu_core_bypass[k] = 1'b0;
      end else begin : g_follower
         assign gpu_core_bypass[k] = ~gpu_sensitive;
      end
   end

endmodule

// File: rtl/llc_share_policy_chk.sv
module llc_share_policy_chk #(
   parameter int NUM_WAYS = 8,
   parameter int CNT_W    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                epoch_end,
   input logic [NUM_WAYS-1:0] way_mask,
   input logic                gpu_sensitive,
   input logic [CNT_W-1:0]    byp_cnt,
   input logic [CNT_W-1:0]    mru_cnt,
   input logic [CNT_W-1:0]    margin
);

   // R7: each side always owns a way
   assert_side_keeps_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|way_mask) && !(&way_mask));

   // R10: CPU ways form a contiguous run from way 0
   assert_mask_low_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((way_mask + 1'b1) & way_mask) == '0);

   // R3: nothing moves between epoch boundaries
   assert_hold_between_epochs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !epoch_end |=> ($stable(way_mask) && $stable(gpu_sensitive)));

   // R4: bypass group at least as good leads to insensitive
   assert_insensitive_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (epoch_end && (mru_cnt <= byp_cnt)) |=> !gpu_sensitive);

   // R5: MRU group ahead by more than margin leads to sensitive
   assert_sensitive_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (epoch_end && ({1'b0, mru_cnt} > ({1'b0, byp_cnt} + {1'b0, margin}))) |=> gpu_sensitive);

endmodule

bind llc_share_policy llc_share_policy_chk #(
   .NUM_WAYS (NUM_WAYS),
   .CNT_W    (CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .epoch_end     (epoch_end),
   .way_mask      (way_mask),
   .gpu_sensitive (gpu_sensitive),
   .byp_cnt       (byp_cnt),
   .mru_cnt       (mru_cnt),
   .margin        (margin)
);

// File: tb/llc_share_policy_tb.sv
`timescale 1ns/1ps
module llc_share_policy_tb_top;

   localparam int N     = 8;
   localparam int CORES = 8;
   localparam int NB    = 1;
   localparam int NM    = 1;
   localparam int CW    = 16;
   localparam int EW    = 16;
   localparam int BOOST = 1;
   localparam int CMAX  = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [EW-1:0] epoch_len = 16'd20;
   logic [CW-1:0] margin = 16'd4;
   logic          byp_e = 1'b0, mru_e = 1'b0, cacc_e = 1'b0, gacc_e = 1'b0;
   logic [N-1:0]  ch = '0, gh = '0;
   logic [N-1:0]  way_mask;
   logic [CORES-1:0] core_byp;
   logic          sens;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   llc_share_policy #(
      .NUM_WAYS(N), .NUM_GPU_CORES(CORES), .NUM_BYP_SAMPLES(NB), .NUM_MRU_SAMPLES(NM),
      .CNT_W(CW), .EPOCH_W(EW), .CPU_BOOST(BOOST)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .epoch_len(epoch_len), .margin(margin),
      .byp_perf_evt(byp_e), .mru_perf_evt(mru_e), .cpu_acc_evt(cacc_e), .gpu_acc_evt(gacc_e),
      .cpu_hit_pos(ch), .gpu_hit_pos(gh),
      .way_mask(way_mask), .gpu_core_bypass(core_byp), .gpu_sensitive(sens)
   );

   // ---------------- reference model ----------------
   int  m_ecnt;
   int  m_perf [4];   // 0 bypass group, 1 MRU group, 2 CPU accesses, 3 GPU accesses
   int  m_ch [N];
   int  m_gh [N];
   bit  m_sens;
   int  m_cpu_ways;

   function automatic int sat_add(int v, bit e);
      if (e && v < CMAX) return v + 1;
      return v;
   endfunction

   function automatic int greedy_ways();
      int c = 1;
      int g = 1;
      for (int s = 0; s < N - 2; s++) begin
         longint cs = longint'(m_ch[c]) * longint'(m_perf[3]);
         longint gs = longint'(m_gh[g]) * longint'(m_perf[2]);
         if (cs >= gs) c++; else g++;
      end
      return c;
   endfunction

   function automatic logic [N-1:0] ways_to_mask(int k);
      logic [N-1:0] m = '0;
      for (int w = 0; w < N; w++) m[w] = (w < k);
      return m;
   endfunction

   function automatic logic [CORES-1:0] exp_cores(bit s);
      logic [CORES-1:0] v;
      for (int k = 0; k < CORES; k++) v[k] = (k < NB) ? 1'b1 : (k < NB + NM) ? 1'b0 : ~s;
      return v;
   endfunction

   always @(posedge clk) begin
      bit endp;
      bit ns;
      int cw;
      if (!rst_n) begin
         m_ecnt = 0;
         for (int i = 0; i < 4; i++) m_perf[i] = 0;
         for (int i = 0; i < N; i++) begin m_ch[i] = 0; m_gh[i] = 0; end
         m_sens = 1'b1;
         m_cpu_ways = N / 2;
      end else begin
         endp = ((m_ecnt + 1) >= int'(epoch_len));
         if (endp) begin
            if (m_perf[1] <= m_perf[0]) ns = 1'b0;
            else if (m_perf[1] > m_perf[0] + int'(margin)) ns = 1'b1;
            else ns = m_sens;
            cw = greedy_ways();
            if (ns) cw = (cw + BOOST > N - 1) ? N - 1 : cw + BOOST;
            m_sens = ns;
            m_cpu_ways = cw;
         end
         m_perf[0] = sat_add(m_perf[0], byp_e);
         m_perf[1] = sat_add(m_perf[1], mru_e);
         m_perf[2] = sat_add(m_perf[2], cacc_e);
         m_perf[3] = sat_add(m_perf[3], gacc_e);
         for (int i = 0; i < N; i++) begin
            m_ch[i] = sat_add(m_ch[i], ch[i]);
            m_gh[i] = sat_add(m_gh[i], gh[i]);
         end
         if (endp) begin
            for (int i = 0; i < 4; i++) m_perf[i] = m_perf[i] >> 1;
            for (int i = 0; i < N; i++) begin m_ch[i] = m_ch[i] >> 1; m_gh[i] = m_gh[i] >> 1; end
         end
         m_ecnt = endp ? 0 : m_ecnt + 1;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic check_eq(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      check_eq("R6 way mask vs model", way_mask, ways_to_mask(m_cpu_ways));
      check_eq("R4 sensitivity vs model", sens, m_sens);
      check_eq("R2 core bypass vector", core_byp, exp_cores(m_sens));
   endtask

   task automatic do_reset(input int len, input int mg);
      @(negedge clk);
      rst_n = 1'b0;
      epoch_len = EW'(len);
      margin = CW'(mg);
      byp_e = 0; mru_e = 0; cacc_e = 0; gacc_e = 0; ch = '0; gh = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // mode: 0 idle, 1 bypass only, 2 MRU only, 3 random, 4 GPU hits everywhere,
   // 5 CPU hits everywhere, 6 access-ratio pattern, 7 partial CPU hits + bypass,
   // 8 partial CPU hits + MRU
   task automatic run(input int mode, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_model();
         byp_e = 0; mru_e = 0; cacc_e = 0; gacc_e = 0; ch = '0; gh = '0;
         case (mode)
            1: byp_e = 1;
            2: mru_e = 1;
            3: begin
               byp_e  = $urandom % 2;
               mru_e  = $urandom % 2;
               cacc_e = ($urandom % 4) == 0;
               gacc_e = ($urandom % 8) != 0;
               for (int w = 0; w < N; w++) begin
                  ch[w] = ($urandom % 4) == 0;
                  gh[w] = ($urandom % 2) == 0;
               end
            end
            4: begin byp_e = 1; cacc_e = 1; gacc_e = 1; gh = '1; end
            5: begin byp_e = 1; cacc_e = 1; gacc_e = 1; ch = '1; end
            6: begin
               byp_e = 1; gacc_e = 1; gh = '1;
               if (i % 2 == 0) ch = '1;
               cacc_e = (i % 4 == 0);
            end
            7, 8: begin
               if (mode == 7) byp_e = 1; else mru_e = 1;
               cacc_e = 1; gacc_e = 1; gh = '1; ch = N'(7);
            end
            default: ;
         endcase
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   logic [N-1:0] held_mask;

   initial begin
      void'($urandom(32'h5eed_1a7e));

      // R1, R10: reset state
      do_reset(20, 4);
      @(negedge clk);
      check_eq("R1 reset way mask", way_mask, ways_to_mask(N / 2));
      check_eq("R1 reset sensitivity", sens, 1);
      check_eq("R10 reset mask low half is CPU", way_mask[0], 1);

      // R4: bypass group wins -> insensitive
      do_reset(20, 4);
      run(1, 20);
      check_eq("R4 bypass-only epoch clears sensitivity", sens, 0);
      check_eq("R4 followers bypass", core_byp, exp_cores(1'b0));
      // R9 + R5: halved history lets MRU group win in next epoch
      run(2, 20);
      check_eq("R9 halved history flips to sensitive", sens, 1);
      check_eq("R5 followers insert", core_byp, exp_cores(1'b1));

      // R5: within the margin band the flag is kept
      do_reset(20, 4);
      run(1, 20);
      margin = 16'd1000;
      run(2, 20);
      check_eq("R5 hysteresis keeps insensitive", sens, 0);

      // R7: GPU dominates -> CPU keeps one way; CPU dominates -> GPU keeps one way
      do_reset(20, 4);
      run(4, 20);
      check_eq("R7 CPU keeps one way", way_mask, ways_to_mask(1));
      do_reset(20, 4);
      run(5, 20);
      check_eq("R7 GPU keeps one way", way_mask, ways_to_mask(N - 1));

      // R6: access-ratio scaling overturns raw GPU hit dominance
      do_reset(20, 4);
      run(6, 20);
      check_eq("R6 ratio-corrected split", way_mask, ways_to_mask(N - 1));

      // R6/R8: partial CPU utility, with and without boost
      do_reset(20, 4);
      run(7, 20);
      check_eq("R6 greedy split insensitive", way_mask, ways_to_mask(3));
      do_reset(20, 4);
      run(8, 20);
      check_eq("R8 boosted split sensitive", way_mask, ways_to_mask(3 + BOOST));
      check_eq("R8 sensitivity", sens, 1);

      // R3: outputs hold mid-epoch under random traffic
      do_reset(20, 4);
      run(3, 20);
      held_mask = way_mask;
      run(3, 15);
      check_eq("R3 mask held inside epoch", way_mask, held_mask);
      // R3 corner: epoch length 1 and 0 decide every cycle
      epoch_len = 16'd1;
      run(3, 200);
      epoch_len = 16'd0;
      run(3, 200);

      // Long random run with changing epoch length and margin (R9 counters checked via model)
      do_reset(24, 3);
      for (int p = 0; p < 8; p++) begin
         epoch_len = EW'(8 + $urandom % 33);
         margin = CW'($urandom % 8);
         run(3, 500);
      end
      run(0, 60);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule